// File: doc/BRIEF.md
# Sliced Torus Route Selector

This block picks the output port for a packet at one router of a two-dimensional torus. Each router is built as two halves. The always-powered half carries the West and South inputs, the East and North outputs and the Local port. The power-gated half carries the East and North inputs and the West and South outputs. The route depends on whether the gated half is awake. While it sleeps, packets may only move East around the X ring and then North around the Y ring. While it is awake, a shortest dimension-ordered route is taken, and that route may use any port.

A packet is presented one flit at a time. The head flit carries the current and destination coordinates, the direction the packet travelled into this router, and the power state. The chosen port is registered one cycle after the head flit is accepted. It is held unchanged until the tail flit passes. A packet that came in moving in a gated direction is never sent back along the always-on direction of the same dimension. If that would happen, the packet keeps its previous direction and waits for the gated half to wake.

A three-state controller frames each packet:
- ST_IDLE: no route is held. A valid head flit moves the controller to ST_OPEN, or to ST_LAST if that head flit is also the tail.
- ST_OPEN: the route is held. A valid tail flit returns the controller to ST_IDLE.
- ST_LAST: a single-flit route is shown for one cycle. A new valid head flit is accepted exactly as in ST_IDLE. Without one, the controller returns to ST_IDLE.

Top module: `sliced_torus_route`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_port` is 0 until a head flit is accepted.
- R2: A head flit (`req_valid`=1, `req_head`=1) is accepted when no multi-flit packet is open. One cycle later `out_valid` is 1 and `out_port` is one-hot, with bit 0 East, bit 1 West, bit 2 North, bit 3 South and bit 4 Local. A flit without a head flag has no effect while no packet is open.
- R3: When the current coordinates equal the destination coordinates, the Local port (bit 4) is chosen in both power modes.
- R4: With the gated half asleep (`slice_awake`=0) and the X coordinates different, East is chosen.
- R5: With the gated half asleep, the X coordinates equal and the Y coordinates different, North is chosen.
- R6: With the gated half awake and the X coordinates different, the East distance is (dst_x − cur_x) mod ring size and the West distance is the ring size minus that value. East is chosen when its distance is not greater than the West distance, otherwise West. A tie goes to East.
- R7: With the gated half awake, the X coordinates equal and the Y coordinates different, the same rule applies to Y. North is chosen when the northward distance is not greater than the southward distance, otherwise South.
- R8: `prev_dir` uses the same one-hot encoding as `out_port`, and 0 means a newly injected packet. If `prev_dir` is West and the rule would give East, West is chosen instead. If `prev_dir` is South and the rule would give North, South is chosen instead. This holds in both power modes.
- R9: While a multi-flit packet is open, the held port does not change. New head flags, changed coordinates, a changed previous direction and a changed power state are all ignored.
- R10: One cycle after a valid tail flit, `out_valid` and `out_port` return to 0. A flit that is both head and tail shows its port for exactly one cycle, and a head flit arriving in that cycle is accepted at once.
- R11: With the gated half asleep and a previous direction that is neither West nor South, West and South are never chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A flit is present this cycle |
| req_head | input | 1 | The flit is a head flit |
| req_tail | input | 1 | The flit is a tail flit |
| cur_x | input | CW | X coordinate of this router |
| cur_y | input | CW | Y coordinate of this router |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| prev_dir | input | 5 | One-hot direction the packet travelled into this router (0 = injected) |
| slice_awake | input | 1 | Gated half is powered (1) or asleep (0) |
| out_port | output | 5 | One-hot selected output port |
| out_valid | output | 1 | A route is held for the current packet |

## Verification
The assertions take for granted two things about the inputs. First, `prev_dir` is one-hot or zero on every head flit. Second, the coordinates stay below the ring size. The bench only drives legal one-hot or zero previous directions and coordinates from 0 to 7 on the default 8×8 ring. Body flits are driven with deliberately changed coordinates, power state and head flags. This exercises the hold rule without ever handing the selector an illegal direction code.

// File: rtl/sliced_route_pkg.sv
package sliced_route_pkg;

    localparam int PORT_N  = 5;
    localparam int P_EAST  = 0;
    localparam int P_WEST  = 1;
    localparam int P_NORTH = 2;
    localparam int P_SOUTH = 3;
    localparam int P_LOCAL = 4;

    typedef logic [PORT_N-1:0] port_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_LAST = 2'd2
    } pkt_state_e;

    function automatic port_vec_t port_bit(input int idx);
        port_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/ring_hop.sv
module ring_hop #(
    parameter int RING = 8,
    parameter int W    = 3
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output logic         aligned,
    output logic         fwd_shorter
);
    localparam logic [W:0] RING_V = (W+1)'(RING);

    logic [W:0] fwd_dist;
    logic [W:0] back_dist;

    always_comb begin
        if (dst >= cur)
            fwd_dist = {1'b0, dst} - {1'b0, cur};
        else
            fwd_dist = {1'b0, dst} + RING_V - {1'b0, cur};
        back_dist   = RING_V - fwd_dist;
        aligned     = (cur == dst);
        // tie goes to the always-on (forward) direction
        fwd_shorter = (fwd_dist <= back_dist);
    end
endmodule

// File: rtl/route_pick.sv
module route_pick
    import sliced_route_pkg::*;
(
    input  logic      x_aligned,
    input  logic      x_fwd,
    input  logic      y_aligned,
    input  logic      y_fwd,
    input  logic      full_on,
    input  logic      came_west,
    input  logic      came_south,
    output port_vec_t port
);
    port_vec_t cand;

    always_comb begin
        if (x_aligned && y_aligned)
            cand = port_bit(P_LOCAL);
        else if (!x_aligned)
            cand = (!full_on || x_fwd) ? port_bit(P_EAST) : port_bit(P_WEST);
        else
            cand = (!full_on || y_fwd) ? port_bit(P_NORTH) : port_bit(P_SOUTH);

        // no turn-back from a gated direction into the always-on one
        if (cand[P_EAST] && came_west)
            port = port_bit(P_WEST);
        else if (cand[P_NORTH] && came_south)
            port = port_bit(P_SOUTH);
        else
            port = cand;
    end
endmodule

// File: rtl/route_fsm.sv
module route_fsm
    import sliced_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_head,
    input  logic      req_tail,
    input  port_vec_t next_port,
    output logic      accept,
    output port_vec_t out_port,
    output logic      out_valid
);
    pkt_state_e state, state_nx;

    assign accept = req_valid && req_head && (state != ST_OPEN);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = req_tail ? ST_LAST : ST_OPEN;
            ST_OPEN: if (req_valid && req_tail) state_nx = ST_IDLE;
            ST_LAST: begin
                if (accept) state_nx = req_tail ? ST_LAST : ST_OPEN;
                else        state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_port  <= '0;
            out_valid <= 1'b0;
        end else if (accept) begin
            out_port  <= next_port;
            out_valid <= 1'b1;
        end else if (state_nx == ST_IDLE) begin
            out_port  <= '0;
            out_valid <= 1'b0;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !(req_valid && req_tail)) |=> ($stable(out_port) && out_valid));
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && req_valid && req_tail) |=> (!out_valid && out_port == '0));
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(out_port));
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_port == '0));
endmodule

// File: rtl/sliced_torus_route.sv
module sliced_torus_route
    import sliced_route_pkg::*;
#(
    parameter int X_RING = 8,
    parameter int Y_RING = 8,
    localparam int MAX_RING = (X_RING > Y_RING) ? X_RING : Y_RING,
    localparam int CW = (MAX_RING > 1) ? $clog2(MAX_RING) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_head,
    input  logic          req_tail,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [4:0]    prev_dir,
    input  logic          slice_awake,
    output logic [4:0]    out_port,
    output logic          out_valid
);
    logic [CW-1:0] cur_c [2];
    logic [CW-1:0] dst_c [2];
    logic [1:0]    al;
    logic [1:0]    fwd;
    port_vec_t     pick;
    logic          accept;

    assign cur_c[0] = cur_x;
    assign cur_c[1] = cur_y;
    assign dst_c[0] = dst_x;
    assign dst_c[1] = dst_y;

    for (genvar d = 0; d < 2; d++) begin : g_dim
        localparam int RN = (d == 0) ? X_RING : Y_RING;
        ring_hop #(.RING(RN), .W(CW)) u_hop (
            .cur         (cur_c[d]),
            .dst         (dst_c[d]),
            .aligned     (al[d]),
            .fwd_shorter (fwd[d])
        );
    end

    route_pick u_pick (
        .x_aligned  (al[0]),
        .x_fwd      (fwd[0]),
        .y_aligned  (al[1]),
        .y_fwd      (fwd[1]),
        .full_on    (slice_awake),
        .came_west  (prev_dir[P_WEST]),
        .came_south (prev_dir[P_SOUTH]),
        .port       (pick)
    );

    route_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_head  (req_head),
        .req_tail  (req_tail),
        .next_port (pick),
        .accept    (accept),
        .out_port  (out_port),
        .out_valid (out_valid)
    );

    // input assumption: legal previous direction code on head flits (R8)
    p_prev_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_head) |-> $onehot0(prev_dir));
    p_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_x == dst_x && cur_y == dst_y) |=> (out_port == 5'b10000));
    p_turnback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prev_dir[P_WEST] && !(cur_x == dst_x && cur_y == dst_y)) |=> !out_port[P_EAST]);
    p_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !slice_awake && !prev_dir[P_WEST] && !prev_dir[P_SOUTH])
            |=> (!out_port[P_WEST] && !out_port[P_SOUTH]));
    p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);
endmodule

// File: tb/sliced_torus_route_test.sv
module sliced_torus_route_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_head = 1'b0, req_tail = 1'b0;
    logic [2:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [4:0] prev_dir = '0;
    logic       slice_awake = 1'b0;
    logic [4:0] out_port;
    logic       out_valid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sliced_torus_route uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
        .req_tail(req_tail), .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x),
        .dst_y(dst_y), .prev_dir(prev_dir), .slice_awake(slice_awake),
        .out_port(out_port), .out_valid(out_valid)
    );

    // {cx, cy, dx, dy, prev, awake, expected}; E=1 W=2 N=4 S=8 L=16
    localparam logic [22:0] VEC [0:20] = '{
        {3'd0,3'd0,3'd0,3'd0,5'd0, 1'b0,5'd16}, // R3 asleep
        {3'd0,3'd0,3'd3,3'd5,5'd0, 1'b0,5'd1},  // R4
        {3'd2,3'd1,3'd2,3'd6,5'd0, 1'b0,5'd4},  // R5
        {3'd5,3'd5,3'd1,3'd2,5'd0, 1'b0,5'd1},  // R4 wrap
        {3'd7,3'd3,3'd7,3'd0,5'd0, 1'b0,5'd4},  // R5 wrap
        {3'd3,3'd3,3'd3,3'd3,5'd0, 1'b1,5'd16}, // R3 awake
        {3'd0,3'd0,3'd3,3'd0,5'd0, 1'b1,5'd1},  // R6 east shorter
        {3'd0,3'd0,3'd5,3'd0,5'd0, 1'b1,5'd2},  // R6 west shorter
        {3'd0,3'd0,3'd4,3'd0,5'd0, 1'b1,5'd1},  // R6 tie
        {3'd2,3'd2,3'd2,3'd7,5'd0, 1'b1,5'd8},  // R7 south shorter
        {3'd2,3'd2,3'd2,3'd6,5'd0, 1'b1,5'd4},  // R7 tie
        {3'd6,3'd1,3'd6,3'd3,5'd0, 1'b1,5'd4},  // R7 north shorter
        {3'd4,3'd0,3'd1,3'd0,5'd2, 1'b0,5'd2},  // R8 wait west
        {3'd1,3'd1,3'd1,3'd4,5'd8, 1'b0,5'd8},  // R8 wait south
        {3'd4,3'd0,3'd4,3'd3,5'd2, 1'b0,5'd4},  // R8 turn allowed
        {3'd4,3'd0,3'd2,3'd0,5'd2, 1'b1,5'd2},  // R6 west keep
        {3'd4,3'd0,3'd5,3'd0,5'd2, 1'b1,5'd2},  // R8 awake block
        {3'd0,3'd0,3'd6,3'd0,5'd1, 1'b1,5'd2},  // R6 east->west ok
        {3'd3,3'd3,3'd3,3'd3,5'd8, 1'b1,5'd16}, // R3 with prev
        {3'd3,3'd5,3'd3,3'd4,5'd8, 1'b1,5'd8},  // R7 south
        {3'd7,3'd7,3'd0,3'd7,5'd4, 1'b0,5'd1}   // R11 asleep east
    };

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got valid/port=%b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [22:0] v, input logic h, input logic t);
        req_valid   = 1'b1;
        req_head    = h;
        req_tail    = t;
        cur_x       = v[22:20];
        cur_y       = v[19:17];
        dst_x       = v[16:14];
        dst_y       = v[13:11];
        prev_dir    = v[10:6];
        slice_awake = v[5];
    endtask

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", {out_valid, out_port}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {out_valid, out_port}, 6'b0);

        // R2: non-head flit while idle has no effect
        drive(VEC[1], 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 no head ignored", {out_valid, out_port}, 6'b0);
        req_valid = 1'b0;

        // table walk, single-flit packets
        for (int i = 0; i < 21; i++) begin
            @(negedge clk);
            drive(VEC[i], 1'b1, 1'b1);
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("R2-table vec %0d", i), {out_valid, out_port}, {1'b1, VEC[i][4:0]});
        end

        // R10: single-flit route lasts one cycle
        @(negedge clk);
        chk("R10 single flit release", {out_valid, out_port}, 6'b0);

        // R10: back-to-back head accepted in ST_LAST
        drive(VEC[7], 1'b1, 1'b1);
        @(negedge clk);
        chk("R10 first of pair", {out_valid, out_port}, 6'b1_00010);
        drive(VEC[2], 1'b1, 1'b1);
        @(negedge clk);
        chk("R10 back-to-back", {out_valid, out_port}, 6'b1_00100);
        req_valid = 1'b0;
        @(negedge clk);

        // R9: multi-flit packet holds its route
        drive(VEC[7], 1'b1, 1'b0);   // awake, west
        @(negedge clk);
        chk("R9 open", {out_valid, out_port}, 6'b1_00010);
        for (int k = 0; k < 3; k++) begin
            drive(VEC[k], 1'b1, 1'b0); // new head flags and inputs ignored
            @(negedge clk);
            chk($sformatf("R9 hold body %0d", k), {out_valid, out_port}, 6'b1_00010);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 hold idle gap", {out_valid, out_port}, 6'b1_00010);
        drive(VEC[5], 1'b0, 1'b1);   // tail
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 tail release", {out_valid, out_port}, 6'b0);

        // R8 in a multi-flit packet
        drive(VEC[13], 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 multi-flit wait south", {out_valid, out_port}, 6'b1_01000);
        drive(VEC[13], 1'b0, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 tail release 2", {out_valid, out_port}, 6'b0);

        // R1: reset mid-packet
        drive(VEC[6], 1'b1, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears", {out_valid, out_port}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule